// File: doc/BRIEF.md
# Four-Port General-Purpose I/O Bank with Open-Drain Control

This block provides four 32-pin general-purpose I/O ports, named A to D. Software reaches them through a single-cycle, halfword-wide register bus. Each port has three registers: a direction register, an output latch (the data register) and an open-drain select register. For every pin, the block drives an output value and an output enable toward the pad. It also samples the pad level through a two-flop synchronizer.

A data-register read never returns the latch. It returns the synchronized pin level, so software can compare what it wrote with what the pad actually shows and detect a contended output. When a pin's open-drain bit is set, the pin pulls low for a latched 0 and releases for a latched 1, which allows a wired-OR connection of several drivers.

Not every open-drain bit is built. The four most significant bits exist only on ports A and C. The four least significant bits exist on no port.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every direction bit and every open-drain bit is 0, and every `pin_oe` bit is 0 (all pins are inputs and push-pull).
- R2: Port p answers at byte addresses 0x20*p to 0x20*p+0x1F, for p from 0 to 3. Within a port the register offsets are:
  - direction: 0x00 and 0x02
  - data: 0x04 and 0x06
  - open-drain: 0x0C and 0x0E

  The lower offset of each pair holds register bits 0..15 and the higher offset holds bits 16..31. Bit 0 is the most significant bit and appears on bus bit 15. Register bit n of port p maps to pin vector position 32p+31-n.
- R3: On a write, `bus_be[1]` enables bus bits 15:8 and `bus_be[0]` enables bus bits 7:0. Bytes that are not enabled keep their value.
- R4: When a pin's direction bit is 1 and its open-drain bit is 0, `pin_oe` is 1 and `pin_out` equals the latched data bit.
- R5: When a pin's direction bit is 1 and its open-drain bit is 1, the pin behaves as follows:
  - latch 0: `pin_oe`=1 and `pin_out`=0
  - latch 1: `pin_oe`=0
- R6: When a pin's direction bit is 0, `pin_oe` is 0 whatever the latch and open-drain bits hold.
- R7: A data-register read returns `pin_in` as it stood two clocks earlier, for input and output pins alike. It never returns the latch.
- R8: Open-drain bits 0..3 exist only on ports A (p=0) and C (p=2). On ports B and D these bits read as 0 and ignore writes.
- R9: Open-drain bits 28..31 read as 0 on all ports, and writes to them are ignored.
- R10: The following accesses are unmapped:
  - an odd address
  - offsets 0x08, 0x0A and 0x10..0x1E
  - addresses from 0x80 upward

  An unmapped read returns 0 and an unmapped write changes nothing. `bus_rdata` is 0 whenever `bus_rd` is 0.
- R11: A data-register write updates the latch whatever the direction bit holds. The latched value drives the pin once the direction bit selects output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe; read data is combinational in the same cycle |
| bus_be | input | 2 | Byte enables: [1] for bits 15:8, [0] for bits 7:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| pin_in | input | 128 | Pad input levels, port p at [32p+31:32p] |
| pin_out | output | 128 | Pad output values |
| pin_oe | output | 128 | Pad output enables, 1 = driven |

## Verification
On every cycle, the assertions check four things: the reset drive state, zero reads at unmapped or idle bus cycles, the fixed zeros in the unbuilt open-drain bits, and the two-clock readback lag of the synchronizer. They also check that a cleared direction half releases its pins on the next cycle. Only the bench's scenarios show the full pin drive for each mode combination. The same holds for byte-enable merging, the latch persisting while a pin is an input, and a contended output reading back the pad level instead of the written value. For these, the bench compares every pin after every write against a model kept from the requirements.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int PORT_W     = 32;
    localparam int HALF_W     = 16;
    localparam int PORT_SPAN  = 32;   // bytes per port window
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_OD   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // halfword index inside a port window -> register
    function automatic reg_sel_e decode_hw(input logic [3:0] hw);
        unique case (hw)
            4'd0, 4'd1: return SEL_DIR;
            4'd2, 4'd3: return SEL_DATA;
            4'd6, 4'd7: return SEL_OD;
            default:    return SEL_NONE;
        endcase
    endfunction

    // implemented open-drain bits; vector bit 31 is register bit 0
    function automatic logic [PORT_W-1:0] od_impl_mask(input int idx);
        logic [PORT_W-1:0] m;
        m = {PORT_W{1'b1}};
        m[3:0] = 4'h0;
        if ((idx % 2) != 0) m[PORT_W-1 -: 4] = 4'h0;
        return m;
    endfunction

    function automatic logic [HALF_W-1:0] be_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [SYNC_DEPTH];

    generate
        for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= din;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = stage_q[SYNC_DEPTH-1];

    // cycles since reset, saturating, to guard the lag check
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    a_r7_sync_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (dout == $past(din, 2)))
        else $error("R7 readback lag broken");
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_bank_pkg::*;
#(
    parameter int PORT_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          reg_sel,
    input  logic              half_lo,
    input  logic [1:0]        be,
    input  logic [HALF_W-1:0] wdata,
    input  logic [PORT_W-1:0] pin_sync,
    output logic [HALF_W-1:0] rd_half,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    localparam logic [PORT_W-1:0] OD_MASK = od_impl_mask(PORT_IDX);

    logic [PORT_W-1:0] dir_q, od_q, latch_q;
    logic [PORT_W-1:0] wmask, wvec;

    always_comb begin
        wmask = '0;
        wvec  = '0;
        if (half_lo) begin
            wmask[HALF_W-1:0] = be_mask(be);
            wvec[HALF_W-1:0]  = wdata;
        end else begin
            wmask[PORT_W-1:HALF_W] = be_mask(be);
            wvec[PORT_W-1:HALF_W]  = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            od_q  <= '0;
        end else if (wr_en) begin
            if (reg_sel == SEL_DIR) dir_q <= (dir_q & ~wmask) | (wvec & wmask);
            if (reg_sel == SEL_OD)  od_q  <= ((od_q & ~wmask) | (wvec & wmask)) & OD_MASK;
        end
    end

    // output latch carries no reset
    always_ff @(posedge clk) begin
        if (wr_en && reg_sel == SEL_DATA)
            latch_q <= (latch_q & ~wmask) | (wvec & wmask);
    end

    assign pin_out = latch_q & ~od_q;
    assign pin_oe  = dir_q & ~(od_q & latch_q);

    logic [PORT_W-1:0] rd_word;
    always_comb begin
        unique case (reg_sel)
            SEL_DIR:  rd_word = dir_q;
            SEL_DATA: rd_word = pin_sync;
            SEL_OD:   rd_word = od_q;
            default:  rd_word = '0;
        endcase
        rd_half = half_lo ? rd_word[HALF_W-1:0] : rd_word[PORT_W-1:HALF_W];
    end

    a_r6_dir_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_DIR && !half_lo && be == 2'b11 && wdata == '0)
            |=> (pin_oe[PORT_W-1:HALF_W] == '0))
        else $error("R6 cleared direction still drives");

    a_r5_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_out & od_q) == '0)
        else $error("R5 open-drain pin driven high");
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [1:0]                  bus_be,
    input  logic [HALF_W-1:0]           bus_wdata,
    output logic [HALF_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
    output logic [NUM_PORTS*PORT_W-1:0] pin_out,
    output logic [NUM_PORTS*PORT_W-1:0] pin_oe
);
    localparam int OFF_W  = $clog2(PORT_SPAN);
    localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int PSEL_W = ADDR_W - OFF_W;

    logic [PSEL_W-1:0] port_full;
    logic [PIDX_W-1:0] port_sel;
    logic              in_range, mapped, half_lo;
    reg_sel_e          reg_sel;

    assign port_full = bus_addr[ADDR_W-1:OFF_W];
    assign port_sel  = port_full[PIDX_W-1:0];
    assign in_range  = (int'(port_full) < NUM_PORTS);
    assign reg_sel   = decode_hw(bus_addr[OFF_W-1:1]);
    assign half_lo   = bus_addr[1];
    assign mapped    = in_range && !bus_addr[0] && (reg_sel != SEL_NONE);

    logic [HALF_W-1:0] port_rd [NUM_PORTS];
    logic [NUM_PORTS*PORT_W-1:0] pin_sync;

    gpio_sync #(.WIDTH(NUM_PORTS*PORT_W)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_sync)
    );

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            gpio_port #(.PORT_IDX(p)) port_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (bus_wr && mapped && (int'(port_sel) == p)),
                .reg_sel (reg_sel),
                .half_lo (half_lo),
                .be      (bus_be),
                .wdata   (bus_wdata),
                .pin_sync(pin_sync[p*PORT_W +: PORT_W]),
                .rd_half (port_rd[p]),
                .pin_out (pin_out[p*PORT_W +: PORT_W]),
                .pin_oe  (pin_oe[p*PORT_W +: PORT_W])
            );
        end
    endgenerate

    assign bus_rdata = (bus_rd && mapped) ? port_rd[port_sel] : '0;

    a_r1_reset_released: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0))
        else $error("R1 pins driven after reset");

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && !bus_addr[0] && int'(port_full) < NUM_PORTS
          && bus_addr[4:1] inside {4'd0,4'd1,4'd2,4'd3,4'd6,4'd7}) |-> (bus_rdata == '0))
        else $error("R10 unmapped read not zero");

    a_r9_od_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && mapped && reg_sel == SEL_OD && half_lo) |-> (bus_rdata[3:0] == 4'h0))
        else $error("R9 open-drain tail bits set");

    a_r8_od_head_bd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && mapped && reg_sel == SEL_OD && !half_lo && port_sel[0])
            |-> (bus_rdata[HALF_W-1 -: 4] == 4'h0))
        else $error("R8 open-drain head bits set on B/D");
endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
    localparam int NP = 4;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NP*32-1:0] pin_in = '0;
    logic [NP*32-1:0] pin_out, pin_oe;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] m_dir [NP];
    logic [31:0] m_od  [NP];
    logic [31:0] m_lat [NP];

    always #5 clk = ~clk;

    gpio_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [31:0] od_mask(int p);
        return (p % 2 == 0) ? 32'hFFFF_FFF0 : 32'h0FFF_FFF0;
    endfunction

    function automatic logic [31:0] exp_oe(int p);
        return m_dir[p] & ~(m_od[p] & m_lat[p]);
    endfunction

    function automatic logic [31:0] exp_out(int p);
        return m_lat[p] & ~m_od[p];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(logic [31:0] old, logic [4:0] off,
                                          logic [1:0] be, logic [15:0] d);
        logic [15:0] m;
        logic [31:0] r;
        m = {{8{be[1]}}, {8{be[0]}}};
        r = old;
        if (off[1]) r[15:0] = (old[15:0] & ~m) | (d & m);
        else        r[31:16] = (old[31:16] & ~m) | (d & m);
        return r;
    endfunction

    task automatic model_write(logic [7:0] a, logic [1:0] be, logic [15:0] d);
        int p;
        logic [3:0] hw;
        if (a >= 8'h80 || a[0]) return;
        p  = int'(a[6:5]);
        hw = a[4:1];
        if (hw <= 4'd1)                 m_dir[p] = merge(m_dir[p], a[4:0], be, d);
        else if (hw <= 4'd3)            m_lat[p] = merge(m_lat[p], a[4:0], be, d);
        else if (hw == 4'd6 || hw == 4'd7) m_od[p] = merge(m_od[p], a[4:0], be, d) & od_mask(p);
    endtask

    task automatic bus_write(logic [7:0] a, logic [1:0] be, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, be, d);
    endtask

    task automatic bus_read(logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check_pins(string req);
        for (int p = 0; p < NP; p++) begin
            check({req, " oe"},  pin_oe[p*32 +: 32], exp_oe(p));
            check({req, " out"}, pin_out[p*32 +: 32] & exp_oe(p), exp_out(p) & exp_oe(p));
        end
    endtask

    initial begin : watchdog
        #1500000;
        n_fails++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : stim
        logic [15:0] rd;
        logic [7:0] a;
        void'($urandom(32'd1234));
        for (int p = 0; p < NP; p++) begin
            m_dir[p] = '0; m_od[p] = '0; m_lat[p] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 oe after reset", pin_oe[31:0] | pin_oe[63:32] | pin_oe[95:64] | pin_oe[127:96], 32'h0);
        bus_read(8'h20, rd); check("R1 dir reset", {16'h0, rd}, 32'h0);
        bus_read(8'h6E, rd); check("R1 od reset", {16'h0, rd}, 32'h0);
        // establish latches (no reset value) - R11 latch written while input
        for (int p = 0; p < NP; p++) begin
            bus_write(8'(p*32 + 4), 2'b11, 16'h0000);
            bus_write(8'(p*32 + 6), 2'b11, 16'h0000);
        end
        bus_write(8'h04, 2'b11, 16'hA5C3);
        check("R11 latch hidden while input", pin_oe[31:16], 16'h0);
        bus_write(8'h00, 2'b11, 16'hFFFF);
        check("R11 latch drives when output", pin_out[31:16], 16'hA5C3);
        check("R4 push-pull oe", pin_oe[31:16], 16'hFFFF);
        // R5 open-drain
        bus_write(8'h0C, 2'b11, 16'hFFFF);
        check("R5 od oe", pin_oe[31:16], 16'h5A3C);
        check("R5 od out low", pin_out[31:16], 16'h0);
        // R3 byte enable
        bus_write(8'h00, 2'b01, 16'h0000);
        bus_read(8'h00, rd); check("R3 byte enable merge", {16'h0, rd}, 32'h0000FF00);
        // R6 direction clear
        bus_write(8'h00, 2'b11, 16'h0000);
        check("R6 dir clear releases", pin_oe[31:16], 16'h0);
        // R8/R9 open-drain masks
        bus_write(8'h2C, 2'b11, 16'hFFFF); bus_write(8'h2E, 2'b11, 16'hFFFF);
        bus_read(8'h2C, rd); check("R8 port B head bits", {16'h0, rd}, 32'h0FFF);
        bus_read(8'h2E, rd); check("R9 port B tail bits", {16'h0, rd}, 32'hFFF0);
        bus_write(8'h4C, 2'b11, 16'hFFFF);
        bus_read(8'h4C, rd); check("R8 port C head bits", {16'h0, rd}, 32'hFFFF);
        bus_write(8'h6C, 2'b11, 16'hFFFF);
        bus_read(8'h6C, rd); check("R8 port D head bits", {16'h0, rd}, 32'h0FFF);
        bus_write(8'h0E, 2'b11, 16'hFFFF);
        bus_read(8'h0E, rd); check("R9 port A tail bits", {16'h0, rd}, 32'hFFF0);
        // R10 unmapped
        bus_write(8'h08, 2'b11, 16'hFFFF); bus_write(8'h90, 2'b11, 16'hFFFF);
        bus_write(8'h01, 2'b11, 16'hFFFF);
        bus_read(8'h08, rd); check("R10 unmapped read", {16'h0, rd}, 32'h0);
        bus_read(8'h90, rd); check("R10 out of range read", {16'h0, rd}, 32'h0);
        bus_read(8'h00, rd); check("R10 unmapped write no effect", {16'h0, rd}, 32'h0);
        @(negedge clk); check("R10 idle rdata", {16'h0, bus_rdata}, 32'h0);
        check_pins("R10 pins unchanged");
        // R7 conflict: push-pull high, pad low
        bus_write(8'h4C, 2'b11, 16'h0000); bus_write(8'h4E, 2'b11, 16'h0000);
        bus_write(8'h44, 2'b11, 16'hFFFF); bus_write(8'h40, 2'b11, 16'hFFFF);
        pin_in[95:64] = 32'h0000_1234;
        repeat (3) @(negedge clk);
        bus_read(8'h44, rd); check("R7 conflict reads pad", {16'h0, rd}, 32'h0000);
        bus_read(8'h46, rd); check("R7 input pin reads pad", {16'h0, rd}, 32'h1234);
        // R7 lag: change then read one cycle later shows old value
        @(negedge clk); pin_in[79:64] = 16'hBEEF;
        bus_addr = 8'h46; bus_rd = 1'b1;
        @(negedge clk); #1 check("R7 one clock lag old", {16'h0, bus_rdata}, 32'h1234);
        @(negedge clk); #1 check("R7 two clock lag new", {16'h0, bus_rdata}, 32'hBEEF);
        bus_rd = 1'b0;
        // random writes checked against model
        for (int i = 0; i < 300; i++) begin
            a = 8'($urandom_range(0, 159));
            if ($urandom_range(0, 7) != 0) a[0] = 1'b0;
            bus_write(a, 2'($urandom_range(0, 3)), 16'($urandom));
            check_pins("R4 R5 R6 random drive");
        end
        for (int p = 0; p < NP; p++) begin
            bus_read(8'(p*32 + 12), rd); check("R8 R9 random od hi", {16'h0, rd}, {16'h0, m_od[p][31:16]});
            bus_read(8'(p*32 + 14), rd); check("R2 random od lo", {16'h0, rd}, {16'h0, m_od[p][15:0]});
            bus_read(8'(p*32 + 2), rd);  check("R2 random dir lo", {16'h0, rd}, {16'h0, m_dir[p][15:0]});
        end
        // random pad readback
        for (int i = 0; i < 40; i++) begin
            int p;
            logic [31:0] v;
            p = $urandom_range(0, NP-1);
            v = $urandom;
            pin_in[p*32 +: 32] = v;
            repeat (3) @(negedge clk);
            bus_read(8'(p*32 + 4), rd); check("R7 random pad hi", {16'h0, rd}, {16'h0, v[31:16]});
            bus_read(8'(p*32 + 6), rd); check("R7 random pad lo", {16'h0, rd}, {16'h0, v[15:0]});
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule